// File: doc/BRIEF.md
# PIO Timing Count Calculator

This block turns the timing needs of one disk drive into the two register bytes that a parallel-ATA host controller uses to pace programmed I/O. The caller supplies the minimum address setup time, the minimum strobe active time and the total cycle time, all in nanoseconds. It also supplies the bus clock period in nanoseconds, the controller revision, a drive index from 0 to 3, and a flag that says whether the other drive on the same channel is present. A start pulse launches the job. A single restoring divider then runs four rounded-up divisions one after another: cycle, setup, active, and the leftover recovery time. The results pass through the controller's floor and ceiling rules and are encoded into an address-timing byte and a read/write-timing byte. A one-cycle done strobe marks the moment both bytes are valid.

Drives 0 and 1 each have a register set of their own. Drives 2 and 3 share one register set. For this reason the block keeps the last limited counts of every drive. When drive 2 or 3 is programmed while its partner is present, each field becomes the slower of the two drives' values.

Top module: `pio_count_calc`

## Requirements
- R1: Each of the cycle, setup and active counts equals the matching time divided by the clock period, rounded up. The recovery time is cycle minus setup minus active, taken as zero when negative, and it is divided and rounded up in the same way.
- R2: The active count is raised to at least 2. The recovery count is the largest of three values: its own rounded count, the cycle count minus (setup count plus active count) taken as zero when negative, and 2.
- R3: A recovery count above 17 is cut to 17, and the amount removed is added to the active count. After that the active count is limited to 16.
- R4: When the revision input is greater than 1, the recovery count is reduced by 1. For every revision the recovery count is then limited to 16.
- R5: For drive index 2 or 3, with peer_present high, the setup, active and recovery counts that are written out are each the maximum of this drive's value and the value last stored for the partner drive (index XOR 1). For drives 0 and 1, and whenever peer_present is low, the drive's own counts are used.
- R6: addr_byte[7:6] encodes the setup count as follows: 4 gives 00, 3 gives 10, 1 or 2 gives 01, and every other value gives 11. addr_byte[5:0] repeats the addr_low input that was captured with start.
- R7: rw_byte[7:4] holds active[3:0] and rw_byte[3:0] holds recovery[3:0], so a count of 16 is written as 0.
- R8: done is high for exactly one cycle, 4*TIME_W+10 clock edges after the edge that accepts start. busy is high from the accepting edge until done. A start pulse seen while busy has no effect on the result or on the timing.
- R9: After reset, addr_byte, rw_byte, done and busy are 0, and every drive's stored counts are setup 4, active 16 and recovery 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a calculation when the block is idle |
| setup_ns | input | TIME_W | Required address setup time, ns |
| active_ns | input | TIME_W | Required strobe active time, ns |
| cycle_ns | input | TIME_W | Required total cycle time, ns |
| clk_ns | input | CLK_W | Bus clock period, ns, nonzero |
| rev | input | 2 | Controller revision |
| drive | input | 2 | Drive index 0..3 |
| peer_present | input | 1 | The partner drive on the shared channel exists |
| addr_low | input | 6 | Low bits kept in the address-timing byte |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle strobe: output bytes are valid |
| addr_byte | output | 8 | Encoded setup count plus the kept low bits |
| rw_byte | output | 8 | Packed active and recovery counts |

## Verification
The bench builds the block with its defaults, TIME_W=10 and CLK_W=6. At these widths, times of up to 1023 ns and clock periods of up to 63 ns can be swept near-exhaustively, with the expected bytes worked out arithmetically. The sweep uses clock periods from 7 to 33 ns. These make the recovery ceiling, the overflow into the active count, the active floor and every setup encoding class all reachable. Drive indices and the peer flag rotate through all values during the sweep, so the shared-channel merge is exercised against a running model of the stored counts. Directed cases cover the reset contents, both revision classes, a negative recovery time and a start pulse issued while the block is busy.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;

   localparam int SETW = 3;
   localparam int CNTW = 5;

   typedef struct packed {
      logic [SETW-1:0] setup;
      logic [CNTW-1:0] act;
      logic [CNTW-1:0] rec;
   } drv_counts_t;

   localparam drv_counts_t SLOWEST = '{setup: 3'd4, act: 5'd16, rec: 5'd16};

   function automatic logic [1:0] enc_setup(input logic [SETW-1:0] s);
      case (s)
         3'd4:        return 2'b00;
         3'd3:        return 2'b10;
         3'd1, 3'd2:  return 2'b01;
         default:     return 2'b11;
      endcase
   endfunction

endpackage

// File: rtl/pio_ceil_div.sv
module pio_ceil_div #(
   parameter int NW = 10,
   parameter int DW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [NW-1:0] num,
   input  logic [DW-1:0] den,
   output logic          valid,
   output logic [NW-1:0] quot
);
   localparam int CW = $clog2(NW + 1);

   logic          running;
   logic [CW-1:0] steps;
   logic [NW-1:0] q;
   logic [DW-1:0] rem;
   logic [NW-1:0] num_l;
   logic [DW-1:0] den_l;
   logic [DW:0]   shifted;
   logic          fits;

   assign shifted = {rem, q[NW-1]};
   assign fits    = shifted >= {1'b0, den_l};
   assign valid   = running && (steps == '0);
   assign quot    = q + NW'(rem != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         steps   <= '0;
         q       <= '0;
         rem     <= '0;
         num_l   <= '0;
         den_l   <= '0;
      end else if (go) begin
         running <= 1'b1;
         steps   <= CW'(NW);
         q       <= num;
         rem     <= '0;
         num_l   <= num;
         den_l   <= den;
      end else if (running) begin
         if (steps != '0) begin
            steps <= steps - 1'b1;
            q     <= {q[NW-2:0], fits};
            rem   <= fits ? DW'(shifted - {1'b0, den_l}) : shifted[DW-1:0];
         end else begin
            running <= 1'b0;
         end
      end
   end

   logic [NW+DW-1:0] prod_hi, prod_lo;
   assign prod_hi = (NW+DW)'(quot) * (NW+DW)'(den_l);
   assign prod_lo = (NW+DW)'(quot - 1'b1) * (NW+DW)'(den_l);

   // rounded-up quotient brackets the numerator
   p_ceil_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && den_l != '0) |->
         ((quot == '0) ? (num_l == '0)
                       : (prod_hi >= (NW+DW)'(num_l) && prod_lo < (NW+DW)'(num_l))));
endmodule

// File: rtl/pio_count_limit.sv
module pio_count_limit
   import pio_calc_pkg::*;
#(
   parameter int NW = 10
) (
   input  logic [NW-1:0] q_cyc,
   input  logic [NW-1:0] q_set,
   input  logic [NW-1:0] q_act,
   input  logic [NW-1:0] q_rec,
   input  logic [1:0]    rev,
   output drv_counts_t   lim
);
   localparam int XW = NW + 2;

   logic [XW-1:0] a0, a1, a2, sa, r_alt, r0, r1, r2, r3;

   always_comb begin
      a0    = (XW'(q_act) < XW'(2)) ? XW'(2) : XW'(q_act);
      sa    = XW'(q_set) + a0;
      r_alt = (XW'(q_cyc) > sa) ? XW'(q_cyc) - sa : '0;
      r0    = (XW'(q_rec) > r_alt) ? XW'(q_rec) : r_alt;
      if (r0 < XW'(2)) r0 = XW'(2);
      if (r0 > XW'(17)) begin
         a1 = a0 + r0 - XW'(17);
         r1 = XW'(17);
      end else begin
         a1 = a0;
         r1 = r0;
      end
      a2 = (a1 > XW'(16)) ? XW'(16) : a1;
      r2 = (rev > 2'd1) ? r1 - 1'b1 : r1;
      r3 = (r2 > XW'(16)) ? XW'(16) : r2;
      lim.setup = (q_set > NW'(7)) ? 3'd7 : q_set[SETW-1:0];
      lim.act   = a2[CNTW-1:0];
      lim.rec   = r3[CNTW-1:0];
   end
endmodule

// File: rtl/pio_byte_pack.sv
module pio_byte_pack
   import pio_calc_pkg::*;
(
   input  drv_counts_t cnt,
   input  logic [5:0]  low_bits,
   output logic [7:0]  addr_val,
   output logic [7:0]  rw_val
);
   assign addr_val = {enc_setup(cnt.setup), low_bits};
   assign rw_val   = {cnt.act[3:0], cnt.rec[3:0]};
endmodule

// File: rtl/pio_count_calc.sv
module pio_count_calc
   import pio_calc_pkg::*;
#(
   parameter int TIME_W = 10,
   parameter int CLK_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [TIME_W-1:0] setup_ns,
   input  logic [TIME_W-1:0] active_ns,
   input  logic [TIME_W-1:0] cycle_ns,
   input  logic [CLK_W-1:0]  clk_ns,
   input  logic [1:0]        rev,
   input  logic [1:0]        drive,
   input  logic              peer_present,
   input  logic [5:0]        addr_low,
   output logic              busy,
   output logic              done,
   output logic [7:0]        addr_byte,
   output logic [7:0]        rw_byte
);
   localparam int NDRV  = 4;
   localparam int NDIV  = 4;
   localparam int SUM_W = TIME_W + 1;

   generate
      if (TIME_W < 6) begin : g_bad_tw
         $error("TIME_W must hold a count of at least 17");
      end
      if (CLK_W < 1) begin : g_bad_cw
         $error("CLK_W must be positive");
      end
   endgenerate

   typedef enum logic [2:0] {ST_IDLE, ST_LAUNCH, ST_WAIT, ST_LIMIT, ST_MERGE} st_t;

   st_t               st;
   logic [1:0]        sel;
   logic [TIME_W-1:0] num_q [NDIV];
   logic [TIME_W-1:0] quo   [NDIV];
   logic [CLK_W-1:0]  den_q;
   logic [1:0]        rev_q, drv_q;
   logic              peer_q;
   logic [5:0]        low_q;
   drv_counts_t       lim_c, lim_q, merged, peer_cnt;
   drv_counts_t       tbl [NDRV];
   logic              div_valid;
   logic [TIME_W-1:0] div_quot;
   logic [SUM_W-1:0]  sa_ns;
   logic [TIME_W-1:0] rec_ns;
   logic [7:0]        addr_c, rw_c;

   assign busy   = (st != ST_IDLE);
   assign sa_ns  = SUM_W'(setup_ns) + SUM_W'(active_ns);
   assign rec_ns = (SUM_W'(cycle_ns) > sa_ns) ? TIME_W'(SUM_W'(cycle_ns) - sa_ns) : '0;

   pio_ceil_div #(.NW(TIME_W), .DW(CLK_W)) u_div (
      .clk(clk), .rst_n(rst_n), .go(st == ST_LAUNCH),
      .num(num_q[sel]), .den(den_q), .valid(div_valid), .quot(div_quot));

   pio_count_limit #(.NW(TIME_W)) u_lim (
      .q_cyc(quo[0]), .q_set(quo[1]), .q_act(quo[2]), .q_rec(quo[3]),
      .rev(rev_q), .lim(lim_c));

   assign peer_cnt = tbl[drv_q ^ 2'd1];

   always_comb begin
      merged = lim_q;
      if (drv_q[1] && peer_q) begin
         if (peer_cnt.setup > merged.setup) merged.setup = peer_cnt.setup;
         if (peer_cnt.act   > merged.act)   merged.act   = peer_cnt.act;
         if (peer_cnt.rec   > merged.rec)   merged.rec   = peer_cnt.rec;
      end
   end

   pio_byte_pack u_pack (.cnt(merged), .low_bits(low_q), .addr_val(addr_c), .rw_val(rw_c));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         sel       <= '0;
         den_q     <= '0;
         rev_q     <= '0;
         drv_q     <= '0;
         peer_q    <= 1'b0;
         low_q     <= '0;
         lim_q     <= SLOWEST;
         done      <= 1'b0;
         addr_byte <= '0;
         rw_byte   <= '0;
         for (int i = 0; i < NDIV; i++) begin
            num_q[i] <= '0;
            quo[i]   <= '0;
         end
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: if (start) begin
               num_q[0] <= cycle_ns;
               num_q[1] <= setup_ns;
               num_q[2] <= active_ns;
               num_q[3] <= rec_ns;
               den_q    <= clk_ns;
               rev_q    <= rev;
               drv_q    <= drive;
               peer_q   <= peer_present;
               low_q    <= addr_low;
               sel      <= '0;
               st       <= ST_LAUNCH;
            end
            ST_LAUNCH: st <= ST_WAIT;
            ST_WAIT: if (div_valid) begin
               quo[sel] <= div_quot;
               if (sel == 2'(NDIV - 1)) st <= ST_LIMIT;
               else begin
                  sel <= sel + 1'b1;
                  st  <= ST_LAUNCH;
               end
            end
            ST_LIMIT: begin
               lim_q <= lim_c;
               st    <= ST_MERGE;
            end
            ST_MERGE: begin
               addr_byte <= addr_c;
               rw_byte   <= rw_c;
               done      <= 1'b1;
               st        <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   genvar g;
   generate
      for (g = 0; g < NDRV; g++) begin : g_tbl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 tbl[g] <= SLOWEST;
            else if (st == ST_MERGE && drv_q == 2'(g))  tbl[g] <= lim_q;
         end
      end
   endgenerate

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_act_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_MERGE) |-> (lim_q.act >= 5'd2 && lim_q.act <= 5'd16));
   p_rec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_MERGE) |-> (lim_q.rec >= 5'd1 && lim_q.rec <= 5'd16));
   p_merge_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_MERGE) |-> (merged.act >= lim_q.act && merged.rec >= lim_q.rec));
endmodule

// File: tb/pio_count_calc_test.sv
`timescale 1ns/1ps
module pio_count_calc_test;
   localparam int TW  = 10;
   localparam int CW  = 6;
   localparam int LAT = 4 * TW + 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [TW-1:0] setup_ns = '0, active_ns = '0, cycle_ns = '0;
   logic [CW-1:0] clk_ns = 6'd1;
   logic [1:0]    rev = '0, drive = '0;
   logic          peer_present = 1'b0;
   logic [5:0]    addr_low = '0;
   logic          busy, done;
   logic [7:0]    addr_byte, rw_byte;

   int checks = 0, failures = 0;
   int m_s[4], m_a[4], m_r[4];
   bit finished = 0;

   always #10 clk = ~clk;

   pio_count_calc #(.TIME_W(TW), .CLK_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .setup_ns(setup_ns),
      .active_ns(active_ns), .cycle_ns(cycle_ns), .clk_ns(clk_ns), .rev(rev),
      .drive(drive), .peer_present(peer_present), .addr_low(addr_low),
      .busy(busy), .done(done), .addr_byte(addr_byte), .rw_byte(rw_byte));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int cdiv(input int t, input int k);
      return (t <= 0) ? 0 : (t + k - 1) / k;
   endfunction

   function automatic int enc(input int s);
      if (s == 4) return 0;
      if (s == 3) return 2;
      if (s == 1 || s == 2) return 1;
      return 3;
   endfunction

   task automatic run(input int s_ns, input int a_ns, input int c_ns, input int k,
                      input int rv, input int drv, input bit peer, input int low,
                      input bit poke, input string tag);
      int cyc, s, a, r, r2, ms, ma, mr, n, ea, er;
      bit seen;
      cyc = cdiv(c_ns, k); s = cdiv(s_ns, k); a = cdiv(a_ns, k);
      if (a < 2) a = 2;
      r  = cdiv(c_ns - s_ns - a_ns, k);
      r2 = cyc - (s + a);
      if (r2 > r) r = r2;
      if (r < 2) r = 2;
      if (r > 17) begin a += r - 17; r = 17; end
      if (a > 16) a = 16;
      if (rv > 1) r -= 1;
      if (r > 16) r = 16;
      ms = s; ma = a; mr = r;
      if (drv >= 2 && peer) begin
         if (m_s[drv ^ 1] > ms) ms = m_s[drv ^ 1];
         if (m_a[drv ^ 1] > ma) ma = m_a[drv ^ 1];
         if (m_r[drv ^ 1] > mr) mr = m_r[drv ^ 1];
      end
      ea = (enc(ms) << 6) | low;
      er = ((ma & 15) << 4) | (mr & 15);
      m_s[drv] = s; m_a[drv] = a; m_r[drv] = r;

      @(negedge clk);
      setup_ns = TW'(s_ns); active_ns = TW'(a_ns); cycle_ns = TW'(c_ns);
      clk_ns = CW'(k); rev = 2'(rv); drive = 2'(drv); peer_present = peer;
      addr_low = 6'(low); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0; seen = 0;
      while (!seen && n < LAT + 20) begin
         @(posedge clk); #1; n++;
         if (done) seen = 1;
         if (poke && n == 3) begin
            start = 1'b1; setup_ns = TW'(999); active_ns = TW'(7);
            drive = 2'(drv ^ 1); addr_low = 6'(~low);
         end
         if (poke && n == 4) start = 1'b0;
      end
      check(seen && n == LAT, {tag, " R8 latency"}, n, LAT);
      check(addr_byte == 8'(ea), {tag, " R1/R2/R5/R6 addr_byte"}, addr_byte, ea);
      check(rw_byte == 8'(er), {tag, " R2/R3/R4/R7 rw_byte"}, rw_byte, er);
      @(posedge clk); #1;
      check(!done && !busy, {tag, " R8 done single pulse"}, {done, busy}, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int cnt;
      int clks[5] = '{7, 15, 20, 30, 33};
      for (int i = 0; i < 4; i++) begin m_s[i] = 4; m_a[i] = 16; m_r[i] = 16; end
      repeat (3) @(posedge clk);
      #1;
      // R9: reset values at the ports
      check(addr_byte == 8'h00 && rw_byte == 8'h00, "R9 reset bytes", {addr_byte, rw_byte}, 0);
      check(!done && !busy, "R9 reset strobes", {done, busy}, 0);
      @(negedge clk); rst_n = 1'b1;

      // R9: drive 2 merged with untouched drive 3 defaults gives slowest bytes
      run(10, 50, 100, 30, 1, 2, 1, 6'h15, 0, "R9 default peer");
      check(addr_byte == 8'h15 && rw_byte == 8'h00, "R9 slowest merge", {addr_byte, rw_byte}, 16'h1500);
      // R4: revision classes
      run(30, 90, 300, 30, 1, 0, 0, 6'h3f, 0, "R4 rev1");
      check(rw_byte == 8'h36, "R4 rev1 value", rw_byte, 8'h36);
      run(30, 90, 300, 30, 2, 0, 0, 6'h00, 0, "R4 rev2");
      check(rw_byte == 8'h35, "R4 rev2 value", rw_byte, 8'h35);
      // R3: recovery overflow moves into active
      run(0, 0, 900, 30, 1, 1, 0, 6'h01, 0, "R3 overflow");
      check(rw_byte == 8'hF0, "R3 overflow value", rw_byte, 8'hF0);
      // R2: floors, and negative recovery time treated as zero
      run(30, 30, 60, 30, 1, 0, 0, 6'h02, 0, "R2 floors");
      check(rw_byte == 8'h22, "R2 floor value", rw_byte, 8'h22);
      run(100, 100, 20, 30, 1, 1, 0, 6'h03, 0, "R2 negative recovery");
      // R6: every setup count class
      for (int s = 0; s <= 6; s++) run(s * 20, 40, 400, 20, 1, 0, 0, s * 9, 0, "R6 setup class");
      // R5: shared channel with and without peer, and primary ignoring peer
      run(160, 300, 800, 20, 1, 3, 0, 6'h0a, 0, "R5 drive3 alone");
      run(20, 40, 120, 20, 1, 2, 1, 6'h0b, 0, "R5 drive2 with peer");
      run(20, 40, 120, 20, 1, 2, 0, 6'h0c, 0, "R5 drive2 no peer");
      run(20, 40, 120, 20, 1, 0, 1, 6'h0d, 0, "R5 drive0 peer ignored");
      // R8: start while busy has no effect
      run(50, 70, 330, 15, 2, 1, 0, 6'h2a, 1, "R8 start while busy");

      // near-exhaustive sweep (R1 R2 R3 R4 R5 R6 R7)
      cnt = 0;
      for (int ci = 0; ci < 5; ci++)
         for (int s = 0; s <= 175; s += 35)
            for (int a = 0; a <= 350; a += 70)
               for (int c = 0; c <= 900; c += 180)
                  for (int rv = 1; rv <= 2; rv++) begin
                     run(s, a, c, clks[ci], rv, cnt % 4, ((cnt / 4) % 2) == 1,
                         (cnt * 7) % 64, 0, "sweep");
                     cnt++;
                  end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule